// File: doc/BRIEF.md
# Cluster power domain sequencer

This block controls the power domain shared by a group of CPU cores. It watches one wakeup request and one wait-for-interrupt (WFI) status line per core. It also holds a small idle-mode register that software arms before the cores go idle. While the domain is in use, the cores are released and run. The domain leaves that state only when every core sits in WFI for two cycles in a row and the armed mode allows it.

The armed mode picks one of two idle states. Retention keeps the rail up in a low-leakage state. Full power-off first asks the cache for a complete flush and waits for its acknowledge before it drops the rail. A wakeup from any core brings the domain back up. The sequencer waits a fixed settle time before it releases the cores, so no core executes before the domain is powered. Every wakeup returns the armed mode to active, so software must arm it again before the next idle period.

Top module: `cpd_seq`

## Requirements
- R1: After reset, the domain is active: `dom_pwr_en`=1, `dom_ret_en`=0, `flush_req`=0, `core_release` all ones, and `mode_rd`=0.
- R2: With mode 2'b00 (active) armed, all cores in WFI for any length of time leave the domain powered and all cores released.
- R3: The domain leaves the active state only when every `core_wfi` bit is 1 for two consecutive cycles. One idle cycle, or any single core out of WFI, keeps it active.
- R4: With mode 2'b01 (retention) armed, an idle entry drives `dom_ret_en`=1 with `dom_pwr_en`=1 and `core_release`=0, two clock edges after all cores assert WFI.
- R5: With mode 2'b10 (power-off) armed, an idle entry first raises `flush_req` with the rail on and the cores held. The rail stays on until `flush_ack` is seen, and the edge after that drops `dom_pwr_en` to 0.
- R6: In retention or off, a wakeup on any single core powers the domain (`dom_pwr_en`=1, `dom_ret_en`=0) on the next edge. `core_release` stays 0 for SETTLE_CYCLES cycles and then goes to all ones.
- R7: A wakeup during the flush keeps `flush_req` up with the cores held until `flush_ack`. The sequencer then returns straight to active without ever dropping the rail.
- R8: Any wakeup while the domain is not active returns the mode register to 2'b00, and `mode_rd` reads 0 after it.
- R9: A mode write while any core is running changes no output. Only `mode_rd` shows the new value. The value 2'b11 behaves as active.
- R10: `core_release` is never set while the rail is off or in retention.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wake | input | NUM_CORES | Per-core wakeup request |
| core_wfi | input | NUM_CORES | Per-core WFI status |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value: 00 active, 01 retention, 10 power-off, 11 active |
| mode_rd | output | 2 | Current armed mode |
| flush_ack | input | 1 | Cache flush complete |
| flush_req | output | 1 | Cache flush request |
| dom_pwr_en | output | 1 | Domain rail enable |
| dom_ret_en | output | 1 | Domain retention enable |
| core_release | output | NUM_CORES | Per-core permission to execute |

## Verification
All cores in WFI is tried under every mode value. This separates the AND-based power-down from the mode gating and shows that 2'b11 falls back to active. Patterns with one core out of WFI, and an all-idle window of only one cycle, separate the two-cycle filter from a plain AND. Wakeups on different single cores in retention, in off and during the flush separate the OR wake path, the settle delay and the flush abort path. A flush acknowledge held back for several cycles shows that the rail waits for it.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_FLUSH   = 3'd1,
    ST_RET     = 3'd2,
    ST_OFF     = 3'd3,
    ST_POWERUP = 3'd4
  } dom_state_e;

  typedef enum logic [1:0] {
    MD_ACTIVE = 2'b00,
    MD_RET    = 2'b01,
    MD_OFF    = 2'b10,
    MD_RSVD   = 2'b11
  } idle_mode_e;

endpackage

// File: rtl/cpd_idle_detect.sv
module cpd_idle_detect #(
  parameter int NUM_CORES = 4,
  parameter int IDLE_HOLD = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_wfi,
  input  logic [NUM_CORES-1:0] core_wake,
  output logic                 idle_stable,
  output logic                 any_wake
);

  localparam int HW = $clog2(IDLE_HOLD + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(IDLE_HOLD - 1);

  logic          all_idle;
  logic [HW-1:0] hold_q;
  logic [HW-1:0] hold_d;
  logic          hold_en;

  // domain may drop only when every core is idle; any core may raise it
  assign all_idle = &core_wfi;
  assign any_wake = |core_wake;

  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_q;
    if (!all_idle) begin
      hold_en = (hold_q != '0);
      hold_d  = '0;
    end else if (hold_q != HOLD_LAST) begin
      hold_en = 1'b1;
      hold_d  = hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign idle_stable = all_idle && (hold_q == HOLD_LAST);

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HOLD_LAST); // R3

endmodule

// File: rtl/cpd_mode_reg.sv
module cpd_mode_reg
  import cpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       revert,
  output idle_mode_e mode_q
);

  idle_mode_e mode_d;
  logic       mode_en;

  // a wakeup outside the active state wins over a software write
  always_comb begin
    mode_en = 1'b0;
    mode_d  = mode_q;
    if (revert) begin
      mode_en = 1'b1;
      mode_d  = MD_ACTIVE;
    end else if (wr) begin
      mode_en = 1'b1;
      mode_d  = idle_mode_e'(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_ACTIVE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  AST_MODE_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    revert |=> (mode_q == MD_ACTIVE)); // R8

endmodule

// File: rtl/cpd_settle_timer.sv
module cpd_settle_timer #(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CNT_LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = run && (cnt_q == CNT_LAST);

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R6

endmodule

// File: rtl/cpd_seq.sv
module cpd_seq
  import cpd_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int SETTLE_CYCLES = 8,
  parameter int IDLE_HOLD     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_wake,
  input  logic [NUM_CORES-1:0] core_wfi,
  input  logic                 mode_wr,
  input  logic [1:0]           mode_wdata,
  output logic [1:0]           mode_rd,
  input  logic                 flush_ack,
  output logic                 flush_req,
  output logic                 dom_pwr_en,
  output logic                 dom_ret_en,
  output logic [NUM_CORES-1:0] core_release
);

  dom_state_e state_q;
  dom_state_e state_d;
  idle_mode_e mode_q;
  logic       idle_stable;
  logic       any_wake;
  logic       settle_done;
  logic       mode_revert;
  logic       abort_q;
  logic       abort_d;
  logic       abort_en;
  logic       run_cores;

  cpd_idle_detect #(
    .NUM_CORES (NUM_CORES),
    .IDLE_HOLD (IDLE_HOLD)
  ) u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_wfi    (core_wfi),
    .core_wake   (core_wake),
    .idle_stable (idle_stable),
    .any_wake    (any_wake)
  );

  assign mode_revert = any_wake && (state_q != ST_ACTIVE);

  cpd_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .revert (mode_revert),
    .mode_q (mode_q)
  );

  cpd_settle_timer #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_POWERUP),
    .done  (settle_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (idle_stable && !any_wake) begin
          if (mode_q == MD_RET)      state_d = ST_RET;
          else if (mode_q == MD_OFF) state_d = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (flush_ack) begin
          state_d = (abort_q || any_wake) ? ST_ACTIVE : ST_OFF;
        end
      end
      ST_RET, ST_OFF: begin
        if (any_wake) state_d = ST_POWERUP;
      end
      ST_POWERUP: begin
        if (settle_done) state_d = ST_ACTIVE;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  // wake seen during the flush turns the power-off into an abort
  always_comb begin
    abort_en = 1'b0;
    abort_d  = abort_q;
    if (state_q == ST_FLUSH) begin
      abort_en = any_wake && !abort_q;
      abort_d  = 1'b1;
    end else if (abort_q) begin
      abort_en = 1'b1;
      abort_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
    end else if (abort_en) begin
      abort_q <= abort_d;
    end
  end

  // outputs decoded from the state register
  assign dom_pwr_en = (state_q != ST_OFF);
  assign dom_ret_en = (state_q == ST_RET);
  assign flush_req  = (state_q == ST_FLUSH);
  assign mode_rd    = mode_q;
  assign run_cores  = (state_q == ST_ACTIVE);

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_rel
    assign core_release[gi] = run_cores;
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && mode_q != MD_RET && mode_q != MD_OFF)
      |=> (state_q == ST_ACTIVE)); // R2

  AST_IDLE_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && !(&core_wfi)) |=> (state_q == ST_ACTIVE)); // R3

  AST_FLUSH_KEEPS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH && !flush_ack) |=> dom_pwr_en); // R5

  AST_WAKE_POWERUP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RET || state_q == ST_OFF) && (|core_wake))
      |=> (state_q == ST_POWERUP)); // R6

  AST_FLUSH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH && abort_q && flush_ack) |=> (state_q == ST_ACTIVE)); // R7

  AST_REL_NEEDS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_release) |-> (dom_pwr_en && !dom_ret_en)); // R10

endmodule

// File: tb/sim_cpd_seq.sv
module sim_cpd_seq;

  localparam int NC  = 4;
  localparam int SET = 8;
  localparam logic [NC-1:0] ALL = {NC{1'b1}};

  logic          clk;
  logic          rst_n;
  logic [NC-1:0] core_wake;
  logic [NC-1:0] core_wfi;
  logic          mode_wr;
  logic [1:0]    mode_wdata;
  logic [1:0]    mode_rd;
  logic          flush_ack;
  logic          flush_req;
  logic          dom_pwr_en;
  logic          dom_ret_en;
  logic [NC-1:0] core_release;

  int n_chk;
  int n_bad;

  cpd_seq #(.NUM_CORES(NC), .SETTLE_CYCLES(SET), .IDLE_HOLD(2)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_wake    (core_wake),
    .core_wfi     (core_wfi),
    .mode_wr      (mode_wr),
    .mode_wdata   (mode_wdata),
    .mode_rd      (mode_rd),
    .flush_ack    (flush_ack),
    .flush_req    (flush_req),
    .dom_pwr_en   (dom_pwr_en),
    .dom_ret_en   (dom_ret_en),
    .core_release (core_release)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [1:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    tick(1);
    mode_wr = 1'b0;
  endtask

  task automatic chk_active(input string req);
    chk(req, "pwr", 32'(dom_pwr_en), 1);
    chk(req, "ret", 32'(dom_ret_en), 0);
    chk(req, "flush", 32'(flush_req), 0);
    chk(req, "release", 32'(core_release), 32'(ALL));
  endtask

  task automatic t_reset;
    chk_active("R1");
    chk("R1", "mode", 32'(mode_rd), 0);
  endtask

  task automatic t_active_mode;
    write_mode(2'b00);
    core_wfi = ALL;
    tick(20);
    chk_active("R2");
    core_wfi = '0;
    write_mode(2'b11);
    core_wfi = ALL;
    tick(10);
    chk_active("R9");
    core_wfi = '0;
    write_mode(2'b00);
  endtask

  task automatic t_filter;
    write_mode(2'b01);
    core_wfi = ALL;
    tick(1);
    core_wfi = 4'b0111;
    tick(1);
    chk_active("R3");
    tick(10);
    chk_active("R3");
    core_wfi = '0;
    tick(2);
    chk_active("R3");
  endtask

  task automatic t_write_quiet;
    write_mode(2'b10);
    tick(5);
    chk_active("R9");
    chk("R9", "mode", 32'(mode_rd), 2);
  endtask

  task automatic t_retention;
    write_mode(2'b01);
    core_wfi = ALL;
    tick(1);
    chk("R3", "release one cycle", 32'(core_release), 32'(ALL));
    tick(1);
    chk("R4", "ret", 32'(dom_ret_en), 1);
    chk("R4", "pwr", 32'(dom_pwr_en), 1);
    chk("R4", "release", 32'(core_release), 0);
    tick(4);
    chk("R4", "ret held", 32'(dom_ret_en), 1);
    core_wake = 4'b0100; core_wfi = '0;
    tick(1);
    core_wake = '0;
    chk("R6", "pwr", 32'(dom_pwr_en), 1);
    chk("R6", "ret", 32'(dom_ret_en), 0);
    chk("R6", "release", 32'(core_release), 0);
    chk("R8", "mode", 32'(mode_rd), 0);
    tick(SET - 1);
    chk("R6", "release before settle", 32'(core_release), 0);
    tick(1);
    chk("R6", "release after settle", 32'(core_release), 32'(ALL));
  endtask

  task automatic t_off;
    write_mode(2'b10);
    core_wfi = ALL;
    tick(2);
    chk("R5", "flush_req", 32'(flush_req), 1);
    chk("R5", "pwr", 32'(dom_pwr_en), 1);
    chk("R5", "release", 32'(core_release), 0);
    tick(5);
    chk("R5", "pwr wait ack", 32'(dom_pwr_en), 1);
    flush_ack = 1'b1;
    tick(1);
    flush_ack = 1'b0;
    chk("R5", "pwr off", 32'(dom_pwr_en), 0);
    chk("R5", "flush_req off", 32'(flush_req), 0);
    chk("R10", "release off", 32'(core_release), 0);
    tick(3);
    chk("R5", "stays off", 32'(dom_pwr_en), 0);
    core_wake = 4'b0001; core_wfi = '0;
    tick(1);
    core_wake = '0;
    chk("R6", "pwr up", 32'(dom_pwr_en), 1);
    chk("R8", "mode", 32'(mode_rd), 0);
    tick(SET);
    chk("R6", "release", 32'(core_release), 32'(ALL));
  endtask

  task automatic t_abort;
    write_mode(2'b10);
    core_wfi = ALL;
    tick(2);
    chk("R7", "flush_req", 32'(flush_req), 1);
    core_wake = 4'b1000; core_wfi = '0;
    tick(1);
    core_wake = '0;
    chk("R7", "flush held", 32'(flush_req), 1);
    chk("R7", "release held", 32'(core_release), 0);
    chk("R8", "mode", 32'(mode_rd), 0);
    tick(3);
    chk("R7", "pwr", 32'(dom_pwr_en), 1);
    flush_ack = 1'b1;
    tick(1);
    flush_ack = 1'b0;
    chk_active("R7");
    tick(5);
    chk_active("R7");
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; core_wake = '0; core_wfi = '0;
    mode_wr = 1'b0; mode_wdata = '0; flush_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_active_mode();
    t_filter();
    t_write_quiet();
    t_retention();
    t_off();
    t_abort();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule